// File: doc/BRIEF.md
# Segmented Prefix-Scan Unit

This block computes an inclusive prefix reduction across the lanes of a vector of signed 32-bit integers, restarting the running result wherever a new segment begins. One pass over a packed batch of ragged rows therefore yields running sums, minima or maxima for each row on its own. Each operation brings a data vector, a second vector operand of per-lane segment identifiers (an ordinary data-register value, not a predicate), a reduction kind and a mask-register index.

The mask index is present on every operation. It picks one register out of a file of lane predicates supplied on a port. Lanes whose predicate bit is clear take part in the scan as the identity of the chosen reduction, but they still receive the running result of their segment. The scan is a log-depth network of registered stages that combine (start-flag, value) pairs. The unit accepts a new operation on every cycle. Each result appears a fixed number of cycles after its start, together with a one-cycle valid strobe. Operations with an illegal kind or a boolean element type are refused, and a refuse strobe marks them instead.

Top module: `segscan_unit`

## Requirements
- R1: A lane begins a new segment when its segment id (bits [32*i+31:32*i] of `seg_i`) differs from the id of lane i-1. Lane 0 always begins a segment. An id that returns to an earlier value still starts a new segment.
- R2: With kind 0 (sum), output lane i is the two's-complement sum, wrapping at 32 bits, of the contributions of lanes from the start of its segment through lane i.
- R3: With kind 1 (max), output lane i is the signed maximum of the contributions from the start of its segment through lane i.
- R4: With kind 2 (min), output lane i is the signed minimum of the contributions from the start of its segment through lane i.
- R5: `midx_i` selects the mask register that occupies bits [16*m+15:16*m] of `mreg_i`, and bit i of that register enables lane i. All 32 indices are usable. A disabled lane contributes 0 for sum, 0x80000000 for max and 0x7FFFFFFF for min, and its output lane still carries the segment's running result.
- R6: `res_valid_o` is high for exactly one cycle, 5 cycles (log2 of the lane count plus 1) after the cycle in which `start_i` was sampled high. A new operation may start on every cycle.
- R7: An operation with kind 3 or with `bool_elt_i` high produces a one-cycle `rej_o` pulse at the same latency and never raises `res_valid_o`.
- R8: While reset is asserted and after its release, `res_valid_o` and `rej_o` are low until an operation completes.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Operation request, sampled on each rising edge |
| kind_i | input | 2 | Reduction kind: 0 sum, 1 max, 2 min, 3 illegal |
| bool_elt_i | input | 1 | Marks a boolean element type, which is refused |
| data_i | input | 512 | Data vector, 16 lanes of 32 bits, lane 0 in the low bits |
| seg_i | input | 512 | Segment-id vector, 16 lanes of 32 bits |
| mreg_i | input | 512 | Mask register file, 32 registers of 16 lane bits |
| midx_i | input | 5 | Index of the mask register gating the input lanes |
| res_o | output | 512 | Segmented inclusive scan result |
| res_valid_o | output | 1 | One-cycle strobe, result on `res_o` is valid |
| rej_o | output | 1 | One-cycle strobe, the operation was refused |

## Verification
The hardest case to reach is a disabled lane that sits at a segment start or inside a long segment. There the identity value has to travel through several network stages and must neither leak across the boundary nor wipe out the running result. Mask registers are therefore filled with irregular lane patterns, including an all-clear register at the top index. These are combined with ragged and recurring segment ids, such as ids that return to an earlier value after three lanes, so that stage distances of 1, 2, 4 and 8 each straddle boundaries and disabled lanes. Two operations are also issued on consecutive cycles, which shows that per-operation kind and flags do not mix inside the pipeline.

// File: rtl/segscan_pkg.sv
package segscan_pkg;

   typedef enum logic [1:0] {
      K_SUM = 2'd0,
      K_MAX = 2'd1,
      K_MIN = 2'd2,
      K_BAD = 2'd3
   } kind_e;

   function automatic logic kind_legal(input kind_e k);
      return k != K_BAD;
   endfunction

endpackage

// File: rtl/segscan_msel.sv
module segscan_msel #(
   parameter int LANES = 16,
   parameter int MREGS = 32,
   localparam int MIW  = $clog2(MREGS)
) (
   input  logic [MREGS*LANES-1:0] mreg_i,
   input  logic [MIW-1:0]         midx_i,
   output logic [LANES-1:0]       lane_en_o
);

   if (MREGS < 2 || (MREGS & (MREGS - 1)) != 0) begin : g_bad_mregs
      $error("segscan_msel: MREGS must be a power of two of at least 2");
   end

   always_comb begin
      lane_en_o = '0;
      for (int r = 0; r < MREGS; r++) begin
         if (midx_i == MIW'(r)) lane_en_o = mreg_i[r*LANES +: LANES];
      end
   end

endmodule

// File: rtl/segscan_prep.sv
module segscan_prep
   import segscan_pkg::*;
#(
   parameter int LANES = 16,
   parameter int DW    = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  kind_e               kind_i,
   input  logic                bool_elt_i,
   input  logic [LANES*DW-1:0] data_i,
   input  logic [LANES*DW-1:0] seg_i,
   input  logic [LANES-1:0]    lane_en_i,
   output logic                vld_o,
   output logic                rej_o,
   output kind_e               kind_o,
   output logic [LANES-1:0]    flag_o,
   output logic [LANES*DW-1:0] val_o
);

   logic              legal;
   logic [DW-1:0]     ident;
   logic [LANES-1:0]  flag_n;
   logic [LANES*DW-1:0] val_n;

   assign legal = kind_legal(kind_i) && !bool_elt_i;

   always_comb begin
      unique case (kind_i)
         K_SUM:   ident = '0;
         K_MAX:   ident = {1'b1, {(DW-1){1'b0}}};
         default: ident = {1'b0, {(DW-1){1'b1}}};
      endcase
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (i == 0) begin : g_first
         assign flag_n[i] = 1'b1;
      end else begin : g_rest
         assign flag_n[i] = seg_i[i*DW +: DW] != seg_i[(i-1)*DW +: DW];
      end
      assign val_n[i*DW +: DW] = lane_en_i[i] ? data_i[i*DW +: DW] : ident;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o <= 1'b0;
         rej_o <= 1'b0;
      end else begin
         vld_o <= start_i && legal;
         rej_o <= start_i && !legal;
      end
   end

   always_ff @(posedge clk) begin
      kind_o <= kind_i;
      flag_o <= flag_n;
      val_o  <= val_n;
   end

   // R1: lane 0 always opens a segment
   a_r1_lane0_start: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> flag_o[0]);

   // R6: every start leaves a pending operation, either accepted or refused
   a_r6_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (vld_o || rej_o));

endmodule

// File: rtl/segscan_stage.sv
module segscan_stage
   import segscan_pkg::*;
#(
   parameter int LANES = 16,
   parameter int DW    = 32,
   parameter int DIST  = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                vld_i,
   input  logic                rej_i,
   input  kind_e               kind_i,
   input  logic [LANES-1:0]    flag_i,
   input  logic [LANES*DW-1:0] val_i,
   output logic                vld_o,
   output logic                rej_o,
   output kind_e               kind_o,
   output logic [LANES-1:0]    flag_o,
   output logic [LANES*DW-1:0] val_o
);

   if (DIST < 1 || DIST >= LANES) begin : g_bad_dist
      $error("segscan_stage: DIST must lie in 1..LANES-1");
   end

   function automatic logic [DW-1:0] merge(input kind_e k,
                                           input logic [DW-1:0] a,
                                           input logic [DW-1:0] b);
      unique case (k)
         K_SUM:   return a + b;
         K_MAX:   return ($signed(a) > $signed(b)) ? a : b;
         default: return ($signed(a) < $signed(b)) ? a : b;
      endcase
   endfunction

   logic [LANES-1:0]    flag_n;
   logic [LANES*DW-1:0] val_n;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (i >= DIST) begin : g_comb
         assign flag_n[i] = flag_i[i] | flag_i[i-DIST];
         assign val_n[i*DW +: DW] = flag_i[i] ? val_i[i*DW +: DW]
                                   : merge(kind_i, val_i[(i-DIST)*DW +: DW],
                                           val_i[i*DW +: DW]);
      end else begin : g_pass
         assign flag_n[i] = flag_i[i];
         assign val_n[i*DW +: DW] = val_i[i*DW +: DW];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o <= 1'b0;
         rej_o <= 1'b0;
      end else begin
         vld_o <= vld_i;
         rej_o <= rej_i;
      end
   end

   always_ff @(posedge clk) begin
      kind_o <= kind_i;
      flag_o <= flag_n;
      val_o  <= val_n;
   end

   // R1: a segment start seen at a stage input is never lost downstream
   a_r1_flag_keep: assert property (@(posedge clk) disable iff (!rst_n)
      vld_i |=> ((flag_o & $past(flag_i)) == $past(flag_i)));

   // R6: a stage delays an accepted operation by exactly one cycle
   a_r6_stage_step: assert property (@(posedge clk) disable iff (!rst_n)
      vld_i |=> vld_o);

endmodule

// File: rtl/segscan_unit.sv
module segscan_unit
   import segscan_pkg::*;
#(
   parameter int LANES = 16,
   parameter int DW    = 32,
   parameter int MREGS = 32,
   localparam int MIW  = $clog2(MREGS),
   localparam int LOG  = $clog2(LANES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   input  logic [1:0]             kind_i,
   input  logic                   bool_elt_i,
   input  logic [LANES*DW-1:0]    data_i,
   input  logic [LANES*DW-1:0]    seg_i,
   input  logic [MREGS*LANES-1:0] mreg_i,
   input  logic [MIW-1:0]         midx_i,
   output logic [LANES*DW-1:0]    res_o,
   output logic                   res_valid_o,
   output logic                   rej_o
);

   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("segscan_unit: LANES must be a power of two of at least 2");
   end
   if (DW < 2) begin : g_bad_dw
      $error("segscan_unit: DW must be at least 2");
   end

   logic [LANES-1:0]    lane_en;
   logic                vld_s  [LOG+1];
   logic                rej_s  [LOG+1];
   kind_e               kind_s [LOG+1];
   logic [LANES-1:0]    flag_s [LOG+1];
   logic [LANES*DW-1:0] val_s  [LOG+1];

   segscan_msel #(.LANES(LANES), .MREGS(MREGS)) u_msel (
      .mreg_i    (mreg_i),
      .midx_i    (midx_i),
      .lane_en_o (lane_en)
   );

   segscan_prep #(.LANES(LANES), .DW(DW)) u_prep (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .kind_i     (kind_e'(kind_i)),
      .bool_elt_i (bool_elt_i),
      .data_i     (data_i),
      .seg_i      (seg_i),
      .lane_en_i  (lane_en),
      .vld_o      (vld_s[0]),
      .rej_o      (rej_s[0]),
      .kind_o     (kind_s[0]),
      .flag_o     (flag_s[0]),
      .val_o      (val_s[0])
   );

   for (genvar d = 0; d < LOG; d++) begin : g_stage
      segscan_stage #(.LANES(LANES), .DW(DW), .DIST(1 << d)) u_stage (
         .clk    (clk),
         .rst_n  (rst_n),
         .vld_i  (vld_s[d]),
         .rej_i  (rej_s[d]),
         .kind_i (kind_s[d]),
         .flag_i (flag_s[d]),
         .val_i  (val_s[d]),
         .vld_o  (vld_s[d+1]),
         .rej_o  (rej_s[d+1]),
         .kind_o (kind_s[d+1]),
         .flag_o (flag_s[d+1]),
         .val_o  (val_s[d+1])
      );
   end

   assign res_o       = val_s[LOG];
   assign res_valid_o = vld_s[LOG];
   assign rej_o       = rej_s[LOG];

   // R7: a finished operation is either delivered or refused, never both
   a_r7_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(res_valid_o && rej_o));

endmodule

// File: tb/tb_segscan_unit.sv
`timescale 1ns/1ps
module tb_segscan_unit;

   localparam int L  = 16;
   localparam int W  = 32;
   localparam int MR = 32;
   localparam int VW = L*W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [1:0]    kind = '0;
   logic          boolv = 1'b0;
   logic [VW-1:0] data = '0;
   logic [VW-1:0] seg = '0;
   logic [MR*L-1:0] mreg = '0;
   logic [4:0]    midx = '0;
   logic [VW-1:0] res;
   logic          res_valid, rej;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   segscan_unit dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .kind_i(kind),
      .bool_elt_i(boolv), .data_i(data), .seg_i(seg), .mreg_i(mreg),
      .midx_i(midx), .res_o(res), .res_valid_o(res_valid), .rej_o(rej)
   );

   // stimulus table: {kind[1:0], id mode[2:0], mask index[4:0], seed[5:0]}
   localparam int NT = 11;
   localparam logic [15:0] TV [NT] = '{
      {2'd0, 3'd0, 5'd0,  6'd1},   // R2 one segment
      {2'd0, 3'd3, 5'd0,  6'd2},   // R1 R2 ragged
      {2'd0, 3'd4, 5'd5,  6'd3},   // R1 R5 recurring ids
      {2'd1, 3'd2, 5'd0,  6'd4},   // R3 groups of four
      {2'd1, 3'd3, 5'd7,  6'd5},   // R3 R5
      {2'd1, 3'd1, 5'd31, 6'd6},   // R5 all lanes off
      {2'd2, 3'd0, 5'd0,  6'd7},   // R4
      {2'd2, 3'd3, 5'd16, 6'd8},   // R4 R5 upper band
      {2'd2, 3'd4, 5'd31, 6'd9},   // R5
      {2'd0, 3'd1, 5'd0,  6'd10},  // R1 every lane alone
      {2'd0, 3'd0, 5'd31, 6'd11}   // R5 sum of identities
   };

   function automatic logic [L-1:0] mask_of(input int r);
      if (r == 0) return '1;
      if (r == MR-1) return '0;
      return 16'(r * 16'h2F1B) ^ 16'hA5C3;
   endfunction

   function automatic logic [W-1:0] id_of(input int mode, input int i);
      case (mode)
         0: return 32'd5;
         1: return 32'(i);
         2: return 32'(i / 4);
         3: return 32'(int'(i >= 3) + int'(i >= 4) + int'(i >= 9) + int'(i >= 15));
         default: return 32'((i / 3) % 2);
      endcase
   endfunction

   function automatic logic [VW-1:0] ids_of(input int mode);
      logic [VW-1:0] v;
      for (int i = 0; i < L; i++) v[i*W +: W] = id_of(mode, i);
      return v;
   endfunction

   function automatic logic [VW-1:0] data_of(input int seed);
      logic [VW-1:0] v;
      for (int i = 0; i < L; i++)
         v[i*W +: W] = 32'(seed) * 32'h9E3779B1 + 32'(i) * 32'h7F4A7C15 + 32'(seed * i * 977);
      return v;
   endfunction

   function automatic logic [W-1:0] ident(input int k);
      if (k == 0) return 32'h0;
      if (k == 1) return 32'h8000_0000;
      return 32'h7FFF_FFFF;
   endfunction

   function automatic logic [VW-1:0] ref_scan(input int k, input logic [VW-1:0] d,
                                              input logic [VW-1:0] ids,
                                              input logic [L-1:0] en);
      logic [VW-1:0] o;
      logic [W-1:0] acc, v;
      acc = '0;
      for (int i = 0; i < L; i++) begin
         if (i == 0 || ids[i*W +: W] != ids[(i-1)*W +: W]) acc = ident(k);
         v = en[i] ? d[i*W +: W] : ident(k);
         if (k == 0) acc = acc + v;
         else if (k == 1) acc = ($signed(v) > $signed(acc)) ? v : acc;
         else acc = ($signed(v) < $signed(acc)) ? v : acc;
         o[i*W +: W] = acc;
      end
      return o;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [VW-1:0] act,
                      input logic [VW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [1:0] k, input bit b, input logic [VW-1:0] d,
                        input logic [VW-1:0] ids, input logic [4:0] mi);
      kind = k; boolv = b; data = d; seg = ids; midx = mi; start = 1'b1;
   endtask

   initial begin
      for (int r = 0; r < MR; r++) mreg[r*L +: L] = mask_of(r);
      repeat (3) @(negedge clk);
      chk(!res_valid && !rej, "R8 in reset", {res_valid, rej}, '0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!res_valid && !rej, "R8 after reset", {res_valid, rej}, '0);

      for (int t = 0; t < NT; t++) begin
         int k, md, mi, sd;
         logic [VW-1:0] d, ids, exp;
         k  = int'(TV[t][15:14]);
         md = int'(TV[t][13:11]);
         mi = int'(TV[t][10:6]);
         sd = int'(TV[t][5:0]);
         d = data_of(sd);
         ids = ids_of(md);
         exp = ref_scan(k, d, ids, mask_of(mi));
         issue(2'(k), 1'b0, d, ids, 5'(mi));
         @(negedge clk) start = 1'b0;
         repeat (4) @(negedge clk);
         chk(res_valid, "R6 valid at latency", VW'(res_valid), VW'(1));
         chk(res == exp, $sformatf("R1-R5 table row %0d (R2 R3 R4 R5)", t), res, exp);
      end

      // R6: strobe timing, exactly one cycle after five edges
      begin
         logic [VW-1:0] d, ids, exp;
         d = data_of(20); ids = ids_of(3);
         exp = ref_scan(0, d, ids, mask_of(0));
         issue(2'd0, 1'b0, d, ids, 5'd0);
         @(negedge clk) start = 1'b0;
         for (int c = 1; c < 5; c++) begin
            chk(!res_valid, "R6 no early valid", VW'(res_valid), '0);
            @(negedge clk);
         end
         chk(res_valid && res == exp, "R6 result at cycle 5", res, exp);
         @(negedge clk);
         chk(!res_valid, "R6 single-cycle strobe", VW'(res_valid), '0);
      end

      // R6: back-to-back operations with different kinds and ids
      begin
         logic [VW-1:0] d1, d2, i1, i2, e1, e2;
         d1 = data_of(30); i1 = ids_of(4);
         d2 = data_of(31); i2 = ids_of(2);
         e1 = ref_scan(1, d1, i1, mask_of(9));
         e2 = ref_scan(2, d2, i2, mask_of(22));
         issue(2'd1, 1'b0, d1, i1, 5'd9);
         @(negedge clk) issue(2'd2, 1'b0, d2, i2, 5'd22);
         @(negedge clk) start = 1'b0;
         repeat (3) @(negedge clk);
         chk(res_valid && res == e1, "R6 R3 first of pair", res, e1);
         @(negedge clk);
         chk(res_valid && res == e2, "R6 R4 second of pair", res, e2);
      end

      // R7: illegal kind 3 is refused
      issue(2'd3, 1'b0, data_of(40), ids_of(0), 5'd0);
      @(negedge clk) start = 1'b0;
      repeat (4) @(negedge clk);
      chk(rej && !res_valid, "R7 kind 3 refused", {res_valid, rej}, VW'(1));
      @(negedge clk);
      chk(!rej, "R7 refuse strobe one cycle", VW'(rej), '0);

      // R7: boolean element type is refused even with a legal kind
      issue(2'd0, 1'b1, data_of(41), ids_of(0), 5'd0);
      @(negedge clk) begin start = 1'b0; boolv = 1'b0; end
      repeat (4) @(negedge clk);
      chk(rej && !res_valid, "R7 boolean refused", {res_valid, rej}, VW'(1));

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule